// File: doc/BRIEF.md
# Co-prime Ring Counter Delay Timer

This block is a free-running long-period timer. It emits a single-cycle `done_o` pulse at a fixed, very long interval without a wide binary counter or a magnitude compare. The count is kept in five short circulating one-hot shift rings. Each ring carries a single set bit and raises its tap once per revolution.

The rings form two cascaded pairs and one lone ring. In a pair, the outer ring advances only on cycles where the inner ring's tap is high, so the two taps are high together once every L*L cycles. When the lengths LA, LB and LC are chosen so that LA^2, LB^2 and LC share no common divisor, the taps are high together once every P = LA^2 * LB^2 * LC cycles. With the defaults (17, 15, 16) this is 1,040,400 cycles.

The taps are merged by two registered AND stages. The first stage ANDs the four pair taps. The second ANDs that result with the lone ring's tap. No output path goes through unregistered combining logic. A synchronous reset restarts the whole sequence.

Top module: `coprime_delay_timer`

## Requirements
- R1: Each ring holds exactly one set bit in every cycle out of reset. Reset loads that bit into stage 0. Each enabled cycle moves the bit up one stage, and the last stage wraps back to stage 0.
- R2: The outer ring of a pair changes state only on cycles where the inner ring's tap (its last stage) is high. On all other cycles it holds its state.
- R3: `done_o` is never high on two consecutive cycles.
- R4: While `rst` is high, `done_o` is low on the following edge. Releasing `rst` restarts the sequence from the initial ring pattern.
- R5: After `rst` is released, the first `done_o` pulse is visible after exactly P+1 rising edges.
- R6: Consecutive `done_o` pulses are exactly P = LA^2*LB^2*LC cycles apart.
- R7: The ring lengths are parameters. The exact period holds for the length sets (3,2,5), giving P=180, and (2,3,7), giving P=252. With the defaults (17,15,16), `done_o` stays low for at least the first 40,000 cycles after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset and reload |
| done_o | output | 1 | Registered single-cycle timer pulse |

## Verification
The assertions check these properties on every cycle:
- every ring stays one-hot (R1);
- an outer ring holds still whenever its inner tap is low, and its tap rises only after an inner pulse (R2);
- `done_o` is never two cycles wide (R3);
- a counter inside the top confirms that each pulse lands exactly P+1 cycles after reset, or exactly P cycles after the previous pulse (R5, R6).

Only the bench scenarios can show the rest:
- the absolute pulse schedule, compared against a plain reference counter for several length sets;
- the restart after a reset applied in mid-count;
- the absence of early pulses in the default configuration.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  // Combined period of the timer for given ring lengths.
  function automatic int unsigned cdt_period(input int unsigned la,
                                             input int unsigned lb,
                                             input int unsigned lc);
    return la * la * lb * lb * lc;
  endfunction

endpackage

// File: rtl/cdt_ring.sv
module cdt_ring #(
  parameter int unsigned LEN = 17,
  parameter int unsigned TAP = LEN - 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tap_o
);

  logic [LEN-1:0] st;

  always_ff @(posedge clk) begin
    if (rst)
      st <= LEN'(1);
    else if (en)
      st <= {st[LEN-2:0], st[LEN-1]};
  end

  assign tap_o = st[TAP];

  // R1
  ring_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(st) == 1);

  // R1
  ring_moves_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> (st != $past(st)));

  // R2
  ring_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(st));

endmodule

// File: rtl/cdt_ring_pair.sv
module cdt_ring_pair #(
  parameter int unsigned LEN = 17
) (
  input  logic clk,
  input  logic rst,
  output logic lo_tap_o,
  output logic hi_tap_o
);

  cdt_ring #(.LEN(LEN), .TAP(LEN - 1)) inner_i (
    .clk(clk), .rst(rst), .en(1'b1), .tap_o(lo_tap_o)
  );

  cdt_ring #(.LEN(LEN), .TAP(LEN - 1)) outer_i (
    .clk(clk), .rst(rst), .en(lo_tap_o), .tap_o(hi_tap_o)
  );

  // R2
  pair_step_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hi_tap_o) |-> $past(lo_tap_o));

endmodule

// File: rtl/cdt_combine.sv
module cdt_combine (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] pair_taps,
  input  logic       lone_tap,
  output logic       done_o
);

  logic quad_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      quad_q <= 1'b0;
      done_o <= 1'b0;
    end else begin
      quad_q <= &pair_taps;
      done_o <= quad_q & lone_tap;
    end
  end

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R4
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !done_o);

endmodule

// File: rtl/coprime_delay_timer.sv
module coprime_delay_timer #(
  parameter int unsigned LEN_A = 17,
  parameter int unsigned LEN_B = 15,
  parameter int unsigned LEN_C = 16
) (
  input  logic clk,
  input  logic rst,
  output logic done_o
);

  import cdt_pkg::*;

  localparam int unsigned PERIOD = cdt_period(LEN_A, LEN_B, LEN_C);

  logic [3:0] pair_taps;
  logic       lone_tap;

  cdt_ring_pair #(.LEN(LEN_A)) pair_a_i (
    .clk(clk), .rst(rst), .lo_tap_o(pair_taps[0]), .hi_tap_o(pair_taps[1])
  );

  cdt_ring_pair #(.LEN(LEN_B)) pair_b_i (
    .clk(clk), .rst(rst), .lo_tap_o(pair_taps[2]), .hi_tap_o(pair_taps[3])
  );

  // Stage-0 tap: this ring is read one cycle later than the pair taps,
  // which lines it up with the first AND register.
  cdt_ring #(.LEN(LEN_C), .TAP(0)) lone_i (
    .clk(clk), .rst(rst), .en(1'b1), .tap_o(lone_tap)
  );

  cdt_combine comb_i (
    .clk(clk), .rst(rst), .pair_taps(pair_taps), .lone_tap(lone_tap),
    .done_o(done_o)
  );

  // Checker: cycles since reset release, or since the previous pulse.
  logic [31:0] gap;
  logic        seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (done_o) begin
      gap  <= 32'd1;
      seen <= 1'b1;
    end else begin
      gap  <= gap + 32'd1;
    end
  end

  // R5 R6
  period_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (gap == (seen ? PERIOD : PERIOD + 32'd1)));

  // R6
  no_late_chk: assert property (@(posedge clk) disable iff (rst)
    seen |-> (gap <= PERIOD));

endmodule

// File: tb/coprime_delay_timer_tb_top.sv
`timescale 1ns/1ps
module coprime_delay_timer_tb_top;

  localparam int P_I   = 180;      // lengths 3,2,5
  localparam int P_B   = 252;      // lengths 2,3,7
  localparam int P_DEF = 1040400;  // lengths 17,15,16

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic done_i, done_b, done_def;

  int checks = 0;
  int errors = 0;
  int n = 0;  // reference counter: rising edges since reset release

  always #2 clk = ~clk;

  coprime_delay_timer #(.LEN_A(3), .LEN_B(2), .LEN_C(5)) dut_i (
    .clk(clk), .rst(rst), .done_o(done_i)
  );
  coprime_delay_timer #(.LEN_A(2), .LEN_B(3), .LEN_C(7)) dut_b (
    .clk(clk), .rst(rst), .done_o(done_b)
  );
  coprime_delay_timer dut_def (
    .clk(clk), .rst(rst), .done_o(done_def)
  );

  function automatic logic exp_done(input int k, input int p);
    return (k >= p + 1) && (((k - (p + 1)) % p) == 0);
  endfunction

  task automatic chk(input string req, input string who,
                     input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle=%0d actual=%0b expected=%0b",
               req, who, n, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    n++;
    @(negedge clk);
  endtask

  task automatic check_all(input string req);
    chk(req, "cfg325", done_i, exp_done(n, P_I));
    chk(req, "cfg237", done_b, exp_done(n, P_B));
    chk(req, "cfgdef", done_def, exp_done(n, P_DEF));
  endtask

  // R4: done low while reset is held
  task automatic test_reset();
    rst = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R4", "cfg325", done_i, 1'b0);
      chk("R4", "cfg237", done_b, 1'b0);
      chk("R4", "cfgdef", done_def, 1'b0);
    end
    rst = 1'b0;
    n = 0;
  endtask

  // R5 R6 R3 R1 R2: exact schedule against the reference counter
  task automatic test_period();
    int pulses = 0;
    for (int i = 0; i < 3 * P_B + 4; i++) begin
      step();
      check_all("R6");
      if (done_i) pulses++;
    end
    // R5: first pulse of the 180 config lands after exactly 181 edges
    checks++;
    if (pulses != ((3 * P_B + 4) - 1) / P_I) begin
      errors++;
      $display("FAIL R5 cfg325 pulse count actual=%0d expected=%0d",
               pulses, ((3 * P_B + 4) - 1) / P_I);
    end
  endtask

  // R4 R5: reset applied in mid-count restarts the schedule
  task automatic test_midreset();
    for (int i = 0; i < 77; i++) step();
    rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R4", "cfg325", done_i, 1'b0);
      chk("R4", "cfg237", done_b, 1'b0);
    end
    rst = 1'b0;
    n = 0;
    for (int i = 0; i < 2 * P_B + 2; i++) begin
      step();
      check_all("R5");
    end
  endtask

  // R7: default lengths give no early pulse; small configs keep period
  task automatic test_default_quiet();
    for (int i = 0; i < 40000; i++) begin
      step();
      check_all("R7");
    end
  endtask

  bit finished = 1'b0;

  initial begin
    @(negedge clk);
    test_reset();
    test_period();
    test_midreset();
    test_reset();
    test_default_quiet();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule